// File: doc/BRIEF.md
# Load Issue and Split Request Controller

This block sits between the load issue stage and a data cache with several request ports. Every cycle it takes up to `NLANE` issued loads, oldest lane first, and turns each into cache read requests. A load that fits in one access uses one port. A load that straddles a boundary is issued as a low half and a high half, and the two halves share one outstanding counter in a per-load-queue-slot table. Responses count that table down. The block reports completion one cycle after the last response, and it gives the byte offset at which each response's data lands in the load's buffer.

The block also polices two special cases. An uncacheable load may reach the cache only when it is both at the head of the load queue and ready to commit. Otherwise it is bounced back with a reschedule pulse. When the cache is blocked, or refuses a request, the block asks for a retry and keeps a single record of the oldest load that must be replayed. The replay logic clears that record with an acknowledge.

Load lanes follow a valid/ready rule. A lane with `ld_valid` high and `ld_ready` high is consumed in that cycle, and its fate (sent, rescheduled, blocked, refused) shows on the outputs in the same cycle. A lane with `ld_ready` low is untouched, and the issuer must present it again. Cache request ports also follow valid/accept: `creq_accept[p]` is sampled in the cycle that `creq_valid[p]` is high, and a request that is not accepted is dropped.

Top module: `ld_issue_ctrl`

## Requirements
- R1: A valid load with `ld_uncache` high that lacks either `ld_at_head` or `ld_at_commit` is consumed with a `resched` pulse on its lane and drives no cache request.
- R2: A cacheable, non-split load whose request is accepted drives one request (`creq_hi`=0, size `ld_lo_size`). `done_valid` then pulses with its index one cycle after its single response.
- R3: A split load drives its low half on the next free port and its high half (`creq_hi`=1, size `ld_hi_size`) on the port after it. The high half is driven only when the low half is accepted in the same cycle. When both are accepted, `done_valid` pulses only after the second response.
- R4: `rsp_off` is 0 for a low-half response and equals the load's `ld_lo_size` for a high-half response.
- R5: If the low half of a split load is accepted and the high half is refused, one response remains outstanding. `retry_req` pulses, and `done_valid` follows the single response.
- R6: If the first request of a load is refused, no second request is driven, nothing stays outstanding for it, and `retry_req` pulses.
- R7: While `cache_blocked` is high, an eligible load is consumed with no request and `retry_req` pulses.
- R8: A load that is blocked by R7, R6 or R5 becomes the blocked record (`blk_valid`, `blk_seq`) unless a record with a smaller or equal sequence number is kept. Among lanes in one cycle, the smallest sequence number wins. Sequence numbers compare as unsigned values.
- R9: `blk_ack` clears the record at the next edge. If a blocked load arrives in the same cycle, that load becomes the new record.
- R10: Ports are given out oldest lane first. Lane 0 is the oldest. A lane whose need (1, or 2 for split) exceeds the ports left is held with `ld_ready` low, and so is every younger lane.
- R11: After reset there is no blocked record, no completion pulse and no outstanding load.
- R12: Completion is registered. `done_valid` and `done_idx` appear the cycle after the response that brings the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | NLANE | Load present on lane |
| ld_ready | output | NLANE | Lane consumed this cycle |
| ld_idx | input | NLANE x IDX_W | Load-queue slot of the load |
| ld_seq | input | NLANE x SEQ_W | Age tag, smaller is older |
| ld_uncache | input | NLANE | Load is uncacheable |
| ld_split | input | NLANE | Load needs two accesses |
| ld_lo_size | input | NLANE x SZ_W | Size of the whole access or of the low half |
| ld_hi_size | input | NLANE x SZ_W | Size of the high half |
| ld_at_head | input | NLANE | Load is at load-queue head |
| ld_at_commit | input | NLANE | Load is ready to commit |
| cache_blocked | input | 1 | Cache cannot take requests |
| creq_valid | output | NPORTS | Request on port |
| creq_accept | input | NPORTS | Cache takes the request |
| creq_idx | output | NPORTS x IDX_W | Slot of requesting load |
| creq_hi | output | NPORTS | Request is a high half |
| creq_size | output | NPORTS x SZ_W | Bytes requested |
| rsp_valid | input | 1 | Cache response |
| rsp_idx | input | IDX_W | Slot of response |
| rsp_hi | input | 1 | Response is for a high half |
| rsp_off | output | SZ_W | Byte offset for response data |
| done_valid | output | 1 | Load finished |
| done_idx | output | IDX_W | Slot of finished load |
| resched | output | NLANE | Uncacheable load bounced |
| retry_req | output | 1 | Ask for a retry of this thread |
| blk_valid | output | 1 | Blocked record held |
| blk_seq | output | SEQ_W | Age tag of blocked record |
| blk_ack | input | 1 | Replay logic consumed record |

## Verification
The bench sweeps every pairing of lane kinds (idle, plain, split, permitted uncacheable, rejected uncacheable) against every pattern of port accepts and both cache-blocked states. The sweep hits the cases where a split load in lane 0 uses up both ports and lane 1 must be held. A design that let lane 1 onto a spare port would show an extra request. A design that drives the high half without checking the low-half accept would show a request on a port with a refused neighbour. A counter that started at two for a half-refused split would never raise completion. The blocked record is driven by ages in both lane orders and by acknowledges that land in the same cycle as new blocks. A design that kept the younger load or dropped a new block on an acknowledge would report the wrong age.

// File: rtl/ld_issue_pkg.sv
package ld_issue_pkg;

  typedef enum logic [2:0] {
    LN_IDLE,
    LN_HOLD,
    LN_RESCHED,
    LN_BLOCKED,
    LN_SENT_ONE,
    LN_SENT_TWO,
    LN_SECOND_MISS,
    LN_FIRST_MISS
  } lane_fate_e;

  function automatic logic [1:0] ports_needed(input logic split);
    return split ? 2'd2 : 2'd1;
  endfunction

  function automatic logic is_block_fate(input lane_fate_e f);
    return (f == LN_BLOCKED) || (f == LN_FIRST_MISS) || (f == LN_SECOND_MISS);
  endfunction

endpackage

// File: rtl/ld_lane_alloc.sv
module ld_lane_alloc
  import ld_issue_pkg::*;
#(
  parameter int NLANE  = 2,
  parameter int NPORTS = 2,
  parameter int IDX_W  = 3,
  parameter int SZ_W   = 4,
  localparam int PCW   = $clog2(NPORTS + 2) + 1
) (
  input  logic [NLANE-1:0]            ld_valid,
  input  logic [NLANE-1:0][IDX_W-1:0] ld_idx,
  input  logic [NLANE-1:0]            ld_uncache,
  input  logic [NLANE-1:0]            ld_split,
  input  logic [NLANE-1:0][SZ_W-1:0]  ld_lo_size,
  input  logic [NLANE-1:0][SZ_W-1:0]  ld_hi_size,
  input  logic [NLANE-1:0]            ld_at_head,
  input  logic [NLANE-1:0]            ld_at_commit,
  input  logic                        cache_blocked,
  input  logic [NPORTS-1:0]           creq_accept,
  output logic [NPORTS-1:0]           creq_valid,
  output logic [NPORTS-1:0][IDX_W-1:0] creq_idx,
  output logic [NPORTS-1:0]           creq_hi,
  output logic [NPORTS-1:0][SZ_W-1:0] creq_size,
  output lane_fate_e                  fate [NLANE],
  output logic [NLANE-1:0]            tbl_we,
  output logic [NLANE-1:0][1:0]       tbl_cnt
);

  logic [NPORTS:0]   acc_pad;
  logic [NLANE-1:0]  first_v;
  logic [NLANE-1:0]  second_v;
  logic [PCW-1:0]    first_p [NLANE];

  assign acc_pad = {1'b0, creq_accept};

  // Oldest-first port allocation; a held lane holds every younger lane.
  always_comb begin
    logic [PCW-1:0] used;
    logic           held;
    logic [1:0]     need;
    used = '0;
    held = 1'b0;
    for (int i = 0; i < NLANE; i++) begin
      fate[i]     = LN_IDLE;
      first_v[i]  = 1'b0;
      second_v[i] = 1'b0;
      first_p[i]  = '0;
      need        = ports_needed(ld_split[i]);
      if (ld_valid[i]) begin
        if (held) begin
          fate[i] = LN_HOLD;
        end else if (ld_uncache[i] && !(ld_at_head[i] && ld_at_commit[i])) begin
          fate[i] = LN_RESCHED;
        end else if (cache_blocked) begin
          fate[i] = LN_BLOCKED;
        end else if (int'(used) + int'(need) > NPORTS) begin
          fate[i] = LN_HOLD;
          held    = 1'b1;
        end else begin
          first_v[i] = 1'b1;
          first_p[i] = used;
          if (!acc_pad[used]) begin
            fate[i] = LN_FIRST_MISS;
          end else if (!ld_split[i]) begin
            fate[i] = LN_SENT_ONE;
          end else begin
            second_v[i] = 1'b1;
            fate[i] = acc_pad[PCW'(used + 1'b1)] ? LN_SENT_TWO : LN_SECOND_MISS;
          end
          used = used + PCW'(need);
        end
      end
    end
  end

  // Port multiplexing: each port is owned by at most one lane half.
  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      creq_valid[p] = 1'b0;
      creq_idx[p]   = '0;
      creq_hi[p]    = 1'b0;
      creq_size[p]  = '0;
      for (int i = 0; i < NLANE; i++) begin
        if (first_v[i] && (first_p[i] == PCW'(p))) begin
          creq_valid[p] = 1'b1;
          creq_idx[p]   = ld_idx[i];
          creq_hi[p]    = 1'b0;
          creq_size[p]  = ld_lo_size[i];
        end
        if (second_v[i] && (PCW'(first_p[i] + 1'b1) == PCW'(p))) begin
          creq_valid[p] = 1'b1;
          creq_idx[p]   = ld_idx[i];
          creq_hi[p]    = 1'b1;
          creq_size[p]  = ld_hi_size[i];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_tbl
      assign tbl_we[g]  = first_v[g];
      assign tbl_cnt[g] = (fate[g] == LN_SENT_TWO) ? 2'd2 :
                          ((fate[g] == LN_SENT_ONE) || (fate[g] == LN_SECOND_MISS)) ? 2'd1 : 2'd0;
    end
  endgenerate

endmodule

// File: rtl/ld_pend_table.sv
module ld_pend_table #(
  parameter int NLANE    = 2,
  parameter int LQ_DEPTH = 8,
  parameter int SZ_W     = 4,
  localparam int IDX_W   = $clog2(LQ_DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NLANE-1:0]            wr_en,
  input  logic [NLANE-1:0][IDX_W-1:0] wr_idx,
  input  logic [NLANE-1:0][1:0]       wr_cnt,
  input  logic [NLANE-1:0][SZ_W-1:0]  wr_losz,
  input  logic                        rsp_valid,
  input  logic [IDX_W-1:0]            rsp_idx,
  input  logic                        rsp_hi,
  output logic [SZ_W-1:0]             rsp_off,
  output logic                        done_valid,
  output logic [IDX_W-1:0]            done_idx
);

  logic [1:0]      cnt_q  [LQ_DEPTH];
  logic [SZ_W-1:0] losz_q [LQ_DEPTH];

  generate
    for (genvar e = 0; e < LQ_DEPTH; e++) begin : g_ent
      logic            hit;
      logic [1:0]      new_cnt;
      logic [SZ_W-1:0] new_sz;

      always_comb begin
        hit     = 1'b0;
        new_cnt = '0;
        new_sz  = '0;
        for (int i = 0; i < NLANE; i++) begin
          if (wr_en[i] && (wr_idx[i] == IDX_W'(e))) begin
            hit     = 1'b1;
            new_cnt = wr_cnt[i];
            new_sz  = wr_losz[i];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q[e]  <= '0;
          losz_q[e] <= '0;
        end else if (hit) begin
          cnt_q[e]  <= new_cnt;
          losz_q[e] <= new_sz;
        end else if (rsp_valid && (rsp_idx == IDX_W'(e)) && (cnt_q[e] != 2'd0)) begin
          cnt_q[e] <= cnt_q[e] - 2'd1;
        end
      end
    end
  endgenerate

  assign rsp_off = rsp_hi ? losz_q[rsp_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_idx   <= '0;
    end else begin
      done_valid <= rsp_valid && (cnt_q[rsp_idx] == 2'd1);
      done_idx   <= rsp_idx;
    end
  end

  // R12
  rsp_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cnt_q[rsp_idx] != 2'd0));

  // R12
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(rsp_valid) && (done_idx == $past(rsp_idx))));

endmodule

// File: rtl/ld_block_rec.sv
module ld_block_rec
  import ld_issue_pkg::*;
#(
  parameter int NLANE = 2,
  parameter int SEQ_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  lane_fate_e                  fate [NLANE],
  input  logic [NLANE-1:0][SEQ_W-1:0] ld_seq,
  input  logic                        blk_ack,
  output logic                        retry_req,
  output logic                        blk_valid,
  output logic [SEQ_W-1:0]            blk_seq
);

  logic             cand_v;
  logic [SEQ_W-1:0] cand_seq;
  logic             keep_v;

  always_comb begin
    cand_v   = 1'b0;
    cand_seq = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (is_block_fate(fate[i]) && (!cand_v || (ld_seq[i] < cand_seq))) begin
        cand_v   = 1'b1;
        cand_seq = ld_seq[i];
      end
    end
  end

  assign retry_req = cand_v;
  assign keep_v    = blk_valid && !blk_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_valid <= 1'b0;
      blk_seq   <= '0;
    end else if (cand_v && (!keep_v || (cand_seq < blk_seq))) begin
      blk_valid <= 1'b1;
      blk_seq   <= cand_seq;
    end else begin
      blk_valid <= keep_v;
    end
  end

  // R8
  oldest_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(blk_valid) && !$past(blk_ack) && blk_valid) |-> (blk_seq <= $past(blk_seq)));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(blk_ack) && !$past(retry_req)) |-> !blk_valid);

endmodule

// File: rtl/ld_issue_ctrl.sv
module ld_issue_ctrl
  import ld_issue_pkg::*;
#(
  parameter int NLANE    = 2,
  parameter int NPORTS   = 2,
  parameter int LQ_DEPTH = 8,
  parameter int SEQ_W    = 8,
  parameter int SZ_W     = 4,
  localparam int IDX_W   = $clog2(LQ_DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NLANE-1:0]              ld_valid,
  output logic [NLANE-1:0]              ld_ready,
  input  logic [NLANE-1:0][IDX_W-1:0]   ld_idx,
  input  logic [NLANE-1:0][SEQ_W-1:0]   ld_seq,
  input  logic [NLANE-1:0]              ld_uncache,
  input  logic [NLANE-1:0]              ld_split,
  input  logic [NLANE-1:0][SZ_W-1:0]    ld_lo_size,
  input  logic [NLANE-1:0][SZ_W-1:0]    ld_hi_size,
  input  logic [NLANE-1:0]              ld_at_head,
  input  logic [NLANE-1:0]              ld_at_commit,
  input  logic                          cache_blocked,
  output logic [NPORTS-1:0]             creq_valid,
  input  logic [NPORTS-1:0]             creq_accept,
  output logic [NPORTS-1:0][IDX_W-1:0]  creq_idx,
  output logic [NPORTS-1:0]             creq_hi,
  output logic [NPORTS-1:0][SZ_W-1:0]   creq_size,
  input  logic                          rsp_valid,
  input  logic [IDX_W-1:0]              rsp_idx,
  input  logic                          rsp_hi,
  output logic [SZ_W-1:0]               rsp_off,
  output logic                          done_valid,
  output logic [IDX_W-1:0]              done_idx,
  output logic [NLANE-1:0]              resched,
  output logic                          retry_req,
  output logic                          blk_valid,
  output logic [SEQ_W-1:0]              blk_seq,
  input  logic                          blk_ack
);

  lane_fate_e             fate [NLANE];
  logic [NLANE-1:0]       tbl_we;
  logic [NLANE-1:0][1:0]  tbl_cnt;

  ld_lane_alloc #(
    .NLANE(NLANE), .NPORTS(NPORTS), .IDX_W(IDX_W), .SZ_W(SZ_W)
  ) u_alloc (
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_uncache(ld_uncache),
    .ld_split(ld_split), .ld_lo_size(ld_lo_size), .ld_hi_size(ld_hi_size),
    .ld_at_head(ld_at_head), .ld_at_commit(ld_at_commit),
    .cache_blocked(cache_blocked), .creq_accept(creq_accept),
    .creq_valid(creq_valid), .creq_idx(creq_idx), .creq_hi(creq_hi),
    .creq_size(creq_size), .fate(fate), .tbl_we(tbl_we), .tbl_cnt(tbl_cnt)
  );

  ld_pend_table #(
    .NLANE(NLANE), .LQ_DEPTH(LQ_DEPTH), .SZ_W(SZ_W)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(ld_idx),
    .wr_cnt(tbl_cnt), .wr_losz(ld_lo_size), .rsp_valid(rsp_valid),
    .rsp_idx(rsp_idx), .rsp_hi(rsp_hi), .rsp_off(rsp_off),
    .done_valid(done_valid), .done_idx(done_idx)
  );

  ld_block_rec #(
    .NLANE(NLANE), .SEQ_W(SEQ_W)
  ) u_blk (
    .clk(clk), .rst_n(rst_n), .fate(fate), .ld_seq(ld_seq),
    .blk_ack(blk_ack), .retry_req(retry_req),
    .blk_valid(blk_valid), .blk_seq(blk_seq)
  );

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign ld_ready[g] = (fate[g] != LN_HOLD);
      assign resched[g]  = (fate[g] == LN_RESCHED);
    end
  endgenerate

  // R7
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> (creq_valid == '0));

  generate
    for (genvar p = 1; p < NPORTS; p++) begin : g_hi_chk
      // R3
      hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (creq_valid[p] && creq_hi[p]) |->
          (creq_valid[p-1] && creq_accept[p-1] && !creq_hi[p-1] &&
           (creq_idx[p-1] == creq_idx[p])));
    end
  endgenerate

  // R3
  port0_not_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid[0] |-> !creq_hi[0]);

endmodule

// File: tb/ld_issue_ctrl_test.sv
`timescale 1ns/1ps
module ld_issue_ctrl_test;

  localparam int NLANE = 2, NPORTS = 2, LQ_DEPTH = 8, SEQ_W = 8, SZ_W = 4;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NLANE-1:0]             ld_valid, ld_ready, ld_uncache, ld_split, ld_at_head, ld_at_commit, resched;
  logic [NLANE-1:0][IDX_W-1:0]  ld_idx;
  logic [NLANE-1:0][SEQ_W-1:0]  ld_seq;
  logic [NLANE-1:0][SZ_W-1:0]   ld_lo_size, ld_hi_size;
  logic                         cache_blocked, rsp_valid, rsp_hi, done_valid, retry_req, blk_valid, blk_ack;
  logic [NPORTS-1:0]            creq_valid, creq_accept, creq_hi;
  logic [NPORTS-1:0][IDX_W-1:0] creq_idx;
  logic [NPORTS-1:0][SZ_W-1:0]  creq_size;
  logic [IDX_W-1:0]             rsp_idx, done_idx;
  logic [SZ_W-1:0]              rsp_off;
  logic [SEQ_W-1:0]             blk_seq;

  ld_issue_ctrl #(.NLANE(NLANE), .NPORTS(NPORTS), .LQ_DEPTH(LQ_DEPTH),
                  .SEQ_W(SEQ_W), .SZ_W(SZ_W)) uut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fate codes in bench: 0 idle,1 hold,2 resched,3 blocked,4 one,5 two,6 second miss,7 first miss
  int fate_e [NLANE];
  int ecnt [NLANE];
  bit ebv;
  int ebs;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ld_valid = '0; ld_uncache = '0; ld_split = '0; ld_at_head = '0; ld_at_commit = '0;
    ld_idx = '0; ld_seq = '0; ld_lo_size = '0; ld_hi_size = '0;
    cache_blocked = 0; creq_accept = '0; rsp_valid = 0; rsp_idx = '0; rsp_hi = 0; blk_ack = 0;
    ebv = 0; ebs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(blk_valid == 0, "R11 blk_valid", blk_valid, 0);
    check(done_valid == 0, "R11 done_valid", done_valid, 0);
    check(creq_valid == 0 && retry_req == 0, "R11 idle outputs", creq_valid, 0);

    for (int n = 0; n < 200; n++) begin
      int k [NLANE];
      int acc, cb, used, base, s [NLANE];
      bit held, cand;
      int cs;
      bit [NPORTS-1:0] ev;
      int eidx [NPORTS], ehi [NPORTS], esz [NPORTS];
      k[0] = n % 5; k[1] = (n / 5) % 5; acc = (n / 25) % 4; cb = n / 100;
      base = (n * 53) % 250;
      if (n % 2 == 1) begin s[0] = base + 3; s[1] = base; end
      else begin s[0] = base; s[1] = base + 1; end

      @(negedge clk);
      for (int i = 0; i < NLANE; i++) begin
        ld_valid[i]     = (k[i] != 0);
        ld_split[i]     = (k[i] == 2);
        ld_uncache[i]   = (k[i] >= 3);
        ld_at_head[i]   = (k[i] == 3) || (k[i] == 4 && i == 0);
        ld_at_commit[i] = (k[i] == 3) || (k[i] == 4 && i == 1);
        ld_idx[i]       = IDX_W'((n % 4) * 2 + i);
        ld_seq[i]       = SEQ_W'(s[i]);
        ld_lo_size[i]   = SZ_W'(2 + i + (n % 3));
        ld_hi_size[i]   = SZ_W'(5 - i);
      end
      cache_blocked = cb[0];
      creq_accept   = NPORTS'(acc);
      blk_ack       = (n % 3 == 0);

      // expected outcome from the requirements
      used = 0; held = 0; ev = '0;
      for (int p = 0; p < NPORTS; p++) begin eidx[p] = 0; ehi[p] = 0; esz[p] = 0; end
      for (int i = 0; i < NLANE; i++) begin
        int need;
        need = (k[i] == 2) ? 2 : 1;
        fate_e[i] = 0;
        if (k[i] != 0) begin
          if (held) fate_e[i] = 1;
          else if (k[i] == 4) fate_e[i] = 2;
          else if (cb != 0) fate_e[i] = 3;
          else if (used + need > NPORTS) begin fate_e[i] = 1; held = 1; end
          else begin
            ev[used] = 1; eidx[used] = ld_idx[i]; ehi[used] = 0; esz[used] = ld_lo_size[i];
            if (((acc >> used) & 1) == 0) fate_e[i] = 7;
            else if (k[i] != 2) fate_e[i] = 4;
            else begin
              ev[used+1] = 1; eidx[used+1] = ld_idx[i]; ehi[used+1] = 1; esz[used+1] = ld_hi_size[i];
              fate_e[i] = (((acc >> (used + 1)) & 1) != 0) ? 5 : 6;
            end
            used += need;
          end
        end
        ecnt[i] = (fate_e[i] == 5) ? 2 : (fate_e[i] == 4 || fate_e[i] == 6) ? 1 : 0;
      end

      #1;
      check(creq_valid == ev, "R10 R3 R6 R7 creq_valid", creq_valid, ev);
      for (int p = 0; p < NPORTS; p++) begin
        if (ev[p]) begin
          check(creq_idx[p] == eidx[p] && creq_hi[p] == ehi[p], "R2 R3 port idx/half",
                creq_idx[p] * 2 + creq_hi[p], eidx[p] * 2 + ehi[p]);
          check(creq_size[p] == esz[p], "R2 R3 port size", creq_size[p], esz[p]);
        end
      end
      cand = 0; cs = 0;
      for (int i = 0; i < NLANE; i++) begin
        if (k[i] != 0)
          check(ld_ready[i] == (fate_e[i] != 1), "R10 ld_ready", ld_ready[i], fate_e[i] != 1);
        check(resched[i] == (fate_e[i] == 2), "R1 resched", resched[i], fate_e[i] == 2);
        if (fate_e[i] == 3 || fate_e[i] == 6 || fate_e[i] == 7) begin
          if (!cand || s[i] < cs) cs = s[i];
          cand = 1;
        end
      end
      check(retry_req == cand, "R5 R6 R7 retry_req", retry_req, cand);

      @(posedge clk);
      begin
        bit keep;
        keep = ebv && !blk_ack;
        if (cand && (!keep || cs < ebs)) begin ebv = 1; ebs = cs; end
        else ebv = keep;
      end
      @(negedge clk);
      ld_valid = '0; blk_ack = 0; cache_blocked = 0; creq_accept = '0;
      check(blk_valid == ebv, "R8 R9 blk_valid", blk_valid, ebv);
      if (ebv) check(blk_seq == ebs, "R8 blk_seq", blk_seq, ebs);

      // drain outstanding responses
      for (int i = 0; i < NLANE; i++) begin
        for (int r = 0; r < ecnt[i]; r++) begin
          int eoff;
          @(negedge clk);
          rsp_valid = 1; rsp_idx = IDX_W'((n % 4) * 2 + i); rsp_hi = (r == 1);
          eoff = (r == 1) ? (2 + i + (n % 3)) : 0;
          #1;
          check(rsp_off == eoff, "R4 rsp_off", rsp_off, eoff);
          @(negedge clk);
          rsp_valid = 0;
          check(done_valid == (r == ecnt[i] - 1), "R2 R3 R5 R12 done_valid", done_valid, r == ecnt[i] - 1);
          if (done_valid)
            check(done_idx == (n % 4) * 2 + i, "R12 done_idx", done_idx, (n % 4) * 2 + i);
        end
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule